// File: doc/BRIEF.md
# Split-Sector Hamming Parity Generator

This block sits beside the byte-wide data path of a NAND flash host and computes single-error-correcting Hamming parity over a 512-byte sector. The sector is handled as two separate 256-byte halves. Each half has its own parity store and its own line parity and column parity. Correction itself is left to software, which compares the stored code with the one computed here.

Software drives the block through mode-register writes. One code clears the parity stores. One data-register read must follow before the calculate code is accepted. The calculate code opens accumulation, and every data byte that passes after it is folded in. The switch from the first half to the second is made by an internal byte counter. A result code turns the data register into a readout port that returns the six parity bytes as three 16-bit words in a fixed interleaved order. The plain data code closes readout. Parity is held inverted, so an erased sector of all-0xFF bytes yields all-ones code bytes.

Top module: `ecc_sector_gen`

## Requirements
- R1: A mode write of 0xF4 clears both parity stores and the byte counter, drops the block out of accumulation and readout (`calc_active` = 0 and `res_valid` = 0 one cycle later), and cancels any earlier dummy read.
- R2: A mode write of 0xB4 starts accumulation (`calc_active` = 1 the next cycle) only if a `data_rd` pulse outside readout has occurred since the last 0xF4 or reset. Otherwise the write is ignored and later bytes leave the result unchanged.
- R3: During accumulation, accepted bytes 0 to 255 fold into the first half and bytes 256 to 511 into the second. Bytes after the 512th are ignored, and so are bytes offered while accumulation is not active.
- R4: For a half, line parity bit 2k is the XOR of the byte parities of all bytes whose in-half address bit k is 0, and bit 2k+1 covers the bytes whose address bit k is 1 (k = 0..7). Every bit is reported inverted.
- R5: The column byte of a half holds, at bits 7..2, the inverted parities CP5..CP0. CP0 covers data bits 0,2,4,6; CP1 covers 1,3,5,7; CP2 covers 0,1,4,5; CP3 covers 2,3,6,7; CP4 covers 0..3; CP5 covers 4..7. Bits 1..0 are 11.
- R6: After a mode write of 0xD4, `res_valid` = 1 and `res_word` shows word 0 = {first LP15..8, first LP7..0}. Each `data_rd` pulse advances to word 1 = {second LP7..0, first column byte} and then to word 2 = {second column byte, second LP15..8}, where the high byte is written first. A pulse on word 2 returns to word 0.
- R7: A mode write of 0x94 ends readout (`res_valid` = 0 and `res_word` = 0) and keeps the stored parity, so a later 0xD4 returns the same words.
- R8: A mode write of any other value changes neither the mode nor the stored parity.
- R9: After reset, `calc_active` = 0, `res_valid` = 0, `res_word` = 0, and the stores are clear, so an immediate 0xD4 reads three 0xFFFF words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_val | input | 8 | Value written to the mode register |
| data_rd | input | 1 | Data register read strobe |
| byte_vld | input | 1 | A data byte passes on the NAND data path |
| byte_in | input | 8 | The data byte |
| calc_active | output | 1 | Accumulation is open |
| res_valid | output | 1 | Readout mode; `res_word` holds a result word |
| res_word | output | 16 | Current result word, zero outside readout |

## Verification
The sector patterns are chosen to pull apart the different kinds of parity. An all-0xFF sector and an all-zero sector both give all-ones codes, which confirms the inversion and the fixed low bits. A single set bit at one address in the first half, and then in the second half, lights exactly one line bit per address bit and three column bits, so a swapped half, a wrong address bit or a misplaced byte in a word shows up. An incrementing sector and a pseudo-random sector test the full Hamming structure. Separate runs cover the missing dummy read, bytes offered while idle, more than 512 bytes, a foreign mode value in the middle of a sector, and readout wrap-around.

// File: rtl/ecc_pkg.sv
// Package: shared mode codes, state type and per-byte column parity for
// the split-sector Hamming parity generator.
// Assumes byte-wide data and 256-byte halves.
package ecc_pkg;

    localparam int BYTE_W      = 8;
    localparam int HALF_ADDR_W = 8;                    // 256 bytes per half
    localparam int LP_W        = 2 * HALF_ADDR_W;      // line parity bits per half
    localparam int CP_W        = 6;                    // column parity bits per half
    localparam int CNT_W       = HALF_ADDR_W + 2;      // counts to 512 and holds there
    localparam int SECTOR_LEN  = 2 << HALF_ADDR_W;     // 512
    localparam int WORD_W      = 16;

    localparam logic [7:0] MODE_CLEAR  = 8'hF4;
    localparam logic [7:0] MODE_CALC   = 8'hB4;
    localparam logic [7:0] MODE_RESULT = 8'hD4;
    localparam logic [7:0] MODE_DATA   = 8'h94;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CALC   = 2'd1,
        ST_RESULT = 2'd2
    } ecc_state_t;

    // Column parity of one byte: even/odd bits, bit pairs, nibbles.
    function automatic logic [CP_W-1:0] col_par(input logic [BYTE_W-1:0] b);
        logic [CP_W-1:0] c;
        c[0] = b[0] ^ b[2] ^ b[4] ^ b[6];
        c[1] = b[1] ^ b[3] ^ b[5] ^ b[7];
        c[2] = b[0] ^ b[1] ^ b[4] ^ b[5];
        c[3] = b[2] ^ b[3] ^ b[6] ^ b[7];
        c[4] = b[0] ^ b[1] ^ b[2] ^ b[3];
        c[5] = b[4] ^ b[5] ^ b[6] ^ b[7];
        return c;
    endfunction

endpackage

// File: rtl/ecc_byte_unit.sv
// ecc_byte_unit: combinational reduction of one data byte into its
// overall parity (for line parity) and its six column parities.
// Assumes the byte is stable for the cycle in which it is accepted.
module ecc_byte_unit
    import ecc_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output logic              byte_par,
    output logic [CP_W-1:0]   byte_cp
);

    // Reduce the byte to its parity terms.
    always_comb begin
        byte_par = ^byte_in;
        byte_cp  = col_par(byte_in);
    end

endmodule

// File: rtl/ecc_half_acc.sv
// ecc_half_acc: parity store for one 256-byte half. Each accepted byte
// toggles one line bit per address bit (even bit when the address bit
// is 0, odd bit when it is 1) and folds its column parities in.
// Outputs are the inverted stored parity. Assumes clr wins over en.
module ecc_half_acc
    import ecc_pkg::*;
#(
    parameter int AW = HALF_ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            en,
    input  logic [AW-1:0]   addr,
    input  logic            byte_par,
    input  logic [CP_W-1:0] byte_cp,
    output logic [2*AW-1:0] lp_inv,
    output logic [CP_W-1:0] cp_inv
);

    logic [2*AW-1:0] lp_q;
    logic [CP_W-1:0] cp_q;

    // One even/odd line-parity pair per address bit.
    for (genvar k = 0; k < AW; k++) begin : g_line
        // Toggle the pair member selected by address bit k.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                lp_q[2*k]   <= 1'b0;
                lp_q[2*k+1] <= 1'b0;
            end else if (en) begin
                if (addr[k]) lp_q[2*k+1] <= lp_q[2*k+1] ^ byte_par;
                else         lp_q[2*k]   <= lp_q[2*k]   ^ byte_par;
            end
        end
    end

    // Fold the column parities of each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cp_q <= '0;
        else if (en)       cp_q <= cp_q ^ byte_cp;
    end

    // Report the store inverted so an erased half reads all ones.
    always_comb begin
        lp_inv = ~lp_q;
        cp_inv = ~cp_q;
    end

endmodule

// File: rtl/ecc_ctrl.sv
// ecc_ctrl: mode sequencing, dummy-read arming, byte counter and readout
// word index. Assumes one mode write and one data read per cycle at most.
module ecc_ctrl
    import ecc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode_wr,
    input  logic [7:0]             mode_val,
    input  logic                   data_rd,
    input  logic                   byte_vld,
    output logic                   acc_clr,
    output logic [1:0]             acc_en,
    output logic [HALF_ADDR_W-1:0] byte_addr,
    output logic                   calc_active,
    output logic                   res_valid,
    output logic [1:0]             word_idx
);

    ecc_state_t       state_q;
    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       idx_q;
    logic             take;
    logic             full;

    // Decode the clear command and whether this byte is accepted.
    always_comb begin
        acc_clr   = mode_wr && (mode_val == MODE_CLEAR);
        full      = (cnt_q >= CNT_W'(SECTOR_LEN));
        take      = (state_q == ST_CALC) && byte_vld && !full && !acc_clr;
        acc_en[0] = take && !cnt_q[HALF_ADDR_W];
        acc_en[1] = take &&  cnt_q[HALF_ADDR_W];
        byte_addr = cnt_q[HALF_ADDR_W-1:0];
    end

    // Mode state follows the recognised mode writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (mode_wr) begin
            case (mode_val)
                MODE_CLEAR:  state_q <= ST_IDLE;
                MODE_CALC:   if (armed_q) state_q <= ST_CALC;
                MODE_RESULT: state_q <= ST_RESULT;
                MODE_DATA:   state_q <= ST_IDLE;
                default:     state_q <= state_q;
            endcase
        end
    end

    // Arm on a data read taken after a clear, outside readout.
    always_ff @(posedge clk) begin
        if (!rst_n || acc_clr)                  armed_q <= 1'b0;
        else if (data_rd && state_q != ST_RESULT) armed_q <= 1'b1;
    end

    // Count accepted bytes up to the sector length.
    always_ff @(posedge clk) begin
        if (!rst_n || acc_clr) cnt_q <= '0;
        else if (take)         cnt_q <= cnt_q + 1'b1;
    end

    // Walk through the three result words, restarting on each result command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= 2'd0;
        end else if (mode_wr && mode_val == MODE_RESULT) begin
            idx_q <= 2'd0;
        end else if (data_rd && state_q == ST_RESULT) begin
            idx_q <= (idx_q == 2'd2) ? 2'd0 : idx_q + 2'd1;
        end
    end

    // Expose the mode flags and the word index.
    always_comb begin
        calc_active = (state_q == ST_CALC);
        res_valid   = (state_q == ST_RESULT);
        word_idx    = idx_q;
    end

endmodule

// File: rtl/ecc_pack.sv
// ecc_pack: builds the column bytes and selects one of the three
// interleaved result words. The output is zero when readout is not active.
module ecc_pack
    import ecc_pkg::*;
(
    input  logic              res_valid,
    input  logic [1:0]        word_idx,
    input  logic [LP_W-1:0]   lp_a,
    input  logic [CP_W-1:0]   cp_a,
    input  logic [LP_W-1:0]   lp_b,
    input  logic [CP_W-1:0]   cp_b,
    output logic [WORD_W-1:0] res_word
);

    logic [7:0] cpb_a;
    logic [7:0] cpb_b;

    // Column bytes carry the parity in the upper six bits over a fixed 11.
    always_comb begin
        cpb_a = {cp_a, 2'b11};
        cpb_b = {cp_b, 2'b11};
    end

    // Pick the word addressed by the readout index.
    always_comb begin
        res_word = '0;
        if (res_valid) begin
            case (word_idx)
                2'd0:    res_word = {lp_a[15:8], lp_a[7:0]};
                2'd1:    res_word = {lp_b[7:0],  cpb_a};
                default: res_word = {cpb_b,      lp_b[15:8]};
            endcase
        end
    end

endmodule

// File: rtl/ecc_sector_gen.sv
// ecc_sector_gen: top of the split-sector Hamming parity generator.
// Bytes seen on the data path while accumulation is open are folded into
// one of two half stores; the result is read back as three words.
// Assumes software follows clear, dummy read, calculate, result, data.
module ecc_sector_gen
    import ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [7:0]        mode_val,
    input  logic              data_rd,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    output logic              calc_active,
    output logic              res_valid,
    output logic [WORD_W-1:0] res_word
);

    logic                   acc_clr;
    logic [1:0]             acc_en;
    logic [HALF_ADDR_W-1:0] byte_addr;
    logic [1:0]             word_idx;
    logic                   byte_par;
    logic [CP_W-1:0]        byte_cp;
    logic [LP_W-1:0]        lp_inv [2];
    logic [CP_W-1:0]        cp_inv [2];

    ecc_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wr     (mode_wr),
        .mode_val    (mode_val),
        .data_rd     (data_rd),
        .byte_vld    (byte_vld),
        .acc_clr     (acc_clr),
        .acc_en      (acc_en),
        .byte_addr   (byte_addr),
        .calc_active (calc_active),
        .res_valid   (res_valid),
        .word_idx    (word_idx)
    );

    ecc_byte_unit u_byte (
        .byte_in  (byte_in),
        .byte_par (byte_par),
        .byte_cp  (byte_cp)
    );

    // One store per half; the counter's half bit picks the enabled one.
    for (genvar h = 0; h < 2; h++) begin : g_half
        ecc_half_acc #(.AW(HALF_ADDR_W)) u_acc (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (acc_clr),
            .en       (acc_en[h]),
            .addr     (byte_addr),
            .byte_par (byte_par),
            .byte_cp  (byte_cp),
            .lp_inv   (lp_inv[h]),
            .cp_inv   (cp_inv[h])
        );
    end

    ecc_pack u_pack (
        .res_valid (res_valid),
        .word_idx  (word_idx),
        .lp_a      (lp_inv[0]),
        .cp_a      (cp_inv[0]),
        .lp_b      (lp_inv[1]),
        .cp_b      (cp_inv[1]),
        .res_word  (res_word)
    );

endmodule

// File: rtl/ecc_sector_chk.sv
// ecc_sector_chk: temporal checks on the mode sequencing and readout of
// ecc_sector_gen, attached by bind.
module ecc_sector_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mode_wr,
    input logic [7:0]  mode_val,
    input logic        data_rd,
    input logic        calc_active,
    input logic        res_valid,
    input logic [15:0] res_word,
    input logic [1:0]  word_idx
);

    // R1: a clear leaves neither accumulation nor readout open.
    a_r1_clear_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_val == 8'hF4) |=> (!calc_active && !res_valid));

    // R2: accumulation only opens on a calculate write.
    a_r2_calc_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(calc_active) |-> $past(mode_wr && mode_val == 8'hB4));

    // R5: the column bytes carry 11 in their low bits.
    a_r5_cp_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && word_idx == 2'd1) |-> (res_word[1:0] == 2'b11));

    a_r5_cp_high_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && word_idx == 2'd2) |-> (res_word[9:8] == 2'b11));

    // R6: without a read or mode write the result word holds.
    a_r6_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !data_rd && !mode_wr) |=> $stable(res_word));

    // R7: the data command closes readout with a zero word.
    a_r7_data_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_val == 8'h94) |=> (!res_valid && res_word == 16'h0000));

    // R6: readout and accumulation are never open together.
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && calc_active));

endmodule

bind ecc_sector_gen ecc_sector_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_wr     (mode_wr),
    .mode_val    (mode_val),
    .data_rd     (data_rd),
    .calc_active (calc_active),
    .res_valid   (res_valid),
    .res_word    (res_word),
    .word_idx    (word_idx)
);

// File: tb/sim_ecc_sector_gen.sv
`timescale 1ns/1ps
module sim_ecc_sector_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [7:0]  mode_val = 8'h00;
    logic        data_rd = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        calc_active;
    logic        res_valid;
    logic [15:0] res_word;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0]  sec [0:511];
    logic [15:0] exp_w [0:2];

    always #2 clk = ~clk;

    ecc_sector_gen u0 (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_mode(input logic [7:0] v);
        @(negedge clk); mode_wr = 1'b1; mode_val = v;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
    endtask

    // Push sector bytes [first, first+count) then extra filler bytes.
    task automatic feed(input int first, input int count, input int extra);
        for (int i = 0; i < count + extra; i++) begin
            @(negedge clk);
            byte_vld = 1'b1;
            byte_in  = (i < count) ? sec[first + i] : 8'h5A;
        end
        @(negedge clk); byte_vld = 1'b0;
    endtask

    // Reference code from the requirement text (R4, R5, R6).
    task automatic ref_code();
        logic [15:0] lp [0:1];
        logic [5:0]  cp [0:1];
        logic [7:0]  cb [0:1];
        for (int h = 0; h < 2; h++) begin
            lp[h] = '0; cp[h] = '0;
            for (int a = 0; a < 256; a++) begin
                logic [7:0] b;
                b = sec[h*256 + a];
                for (int k = 0; k < 8; k++)
                    lp[h][2*k + ((a >> k) & 1)] ^= ^b;
                for (int j = 0; j < 8; j++) begin
                    cp[h][0 + (j & 1)]        ^= b[j];
                    cp[h][2 + ((j >> 1) & 1)] ^= b[j];
                    cp[h][4 + ((j >> 2) & 1)] ^= b[j];
                end
            end
            lp[h] = ~lp[h];
            cb[h] = {~cp[h], 2'b11};
        end
        exp_w[0] = lp[0];
        exp_w[1] = {lp[1][7:0], cb[0]};
        exp_w[2] = {cb[1], lp[1][15:8]};
    endtask

    // Enter readout and compare three words, then one wrap read.
    task automatic read_check(input string req, input bit wrap);
        write_mode(8'hD4);
        for (int w = 0; w < 3; w++) begin
            check(req, res_word, exp_w[w]);
            pulse_rd();
        end
        if (wrap) check("R6 wrap", res_word, exp_w[0]);
        write_mode(8'h94);
    endtask

    task automatic run_sector(input string req);
        write_mode(8'hF4);
        pulse_rd();
        write_mode(8'hB4);
        check("R2 calc open", {15'd0, calc_active}, 16'd1);
        feed(0, 512, 0);
        ref_code();
        read_check(req, 1'b0);
    endtask

    task automatic t_reset();
        check("R9 calc_active", {15'd0, calc_active}, 16'd0);
        check("R9 res_valid",   {15'd0, res_valid},   16'd0);
        check("R9 res_word",    res_word,             16'h0000);
        for (int i = 0; i < 512; i++) sec[i] = 8'hFF;
        ref_code();
        read_check("R9 cleared store", 1'b0);
    endtask

    task automatic t_patterns();
        for (int i = 0; i < 512; i++) sec[i] = 8'hFF;
        run_sector("R4 R5 erased");
        for (int i = 0; i < 512; i++) sec[i] = 8'h00;
        run_sector("R4 R5 zeros");
        for (int i = 0; i < 512; i++) sec[i] = 8'h00;
        sec[8'h5A] = 8'h01;
        run_sector("R3 R4 single bit first half");
        for (int i = 0; i < 512; i++) sec[i] = 8'h00;
        sec[9'h1A7] = 8'h80;
        run_sector("R3 R4 single bit second half");
        for (int i = 0; i < 512; i++) sec[i] = 8'(i * 7 + (i >> 8));
        run_sector("R4 R5 R6 incrementing");
        begin
            logic [15:0] s = 16'hACE1;
            for (int i = 0; i < 512; i++) begin
                s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
                sec[i] = s[7:0];
            end
        end
        run_sector("R4 R5 pseudo-random");
        read_check("R7 retained", 1'b1);
    endtask

    task automatic t_no_arm();
        for (int i = 0; i < 512; i++) sec[i] = 8'(i ^ 8'h3C);
        write_mode(8'hF4);
        write_mode(8'hB4);
        check("R2 no dummy read", {15'd0, calc_active}, 16'd0);
        feed(0, 512, 0);
        for (int i = 0; i < 512; i++) sec[i] = 8'hFF;
        ref_code();
        read_check("R2 bytes ignored", 1'b0);
    endtask

    task automatic t_idle_and_overflow();
        for (int i = 0; i < 512; i++) sec[i] = 8'(i * 13);
        write_mode(8'hF4);
        pulse_rd();
        write_mode(8'hB4);
        feed(0, 512, 9);
        ref_code();
        read_check("R3 beyond 512 ignored", 1'b0);
        feed(0, 40, 0);
        read_check("R3 idle bytes ignored", 1'b0);
    endtask

    task automatic t_foreign_mode();
        for (int i = 0; i < 512; i++) sec[i] = 8'(255 - i);
        write_mode(8'hF4);
        pulse_rd();
        write_mode(8'hB4);
        feed(0, 200, 0);
        write_mode(8'h0C);
        check("R8 foreign mode keeps calc", {15'd0, calc_active}, 16'd1);
        feed(200, 312, 0);
        ref_code();
        read_check("R8 parity kept", 1'b0);
        write_mode(8'hF4);
        check("R1 clear", {15'd0, calc_active}, 16'd0);
        for (int i = 0; i < 512; i++) sec[i] = 8'hFF;
        ref_code();
        read_check("R1 store cleared", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_patterns();
        t_no_arm();
        t_idle_and_overflow();
        t_foreign_mode();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule